// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block decides when an 8-bit microcontroller core takes an interrupt. It has two request sources. The first is an active-low external pin, which is synchronized and then watched for falling edges. The second is a one-cycle overflow pulse from a timer. Each source sets its own sticky request flag. The flags sit in one 8-bit control register, together with three enable bits: a master enable, an external enable and a timer enable. Software reads and writes this register at a fixed data address.

Requests are evaluated only in a clock cycle in which the core's phase strobe is high. In that cycle, a request is accepted if its flag is set, its own enable is set, the master enable is set and the core reports that its stack is not full. The block then raises a one-cycle take pulse and drives the vector address. At the same clock edge it clears the flag of the accepted source and drops the master enable, so nothing else can interrupt the handler. The core's return strobes decide what happens at the end of the handler: the interrupt-return strobe turns the master enable back on, and a plain return leaves it alone.

Top module: `irq_pair_ctrl`

## Requirements
- R1: A falling edge on `ext_irq_n` sets register bit 4, SYNC_STAGES+1 clock edges after the pin changes. A pin held low sets the bit only once. A rising edge does not set it.
- R2: A high `tmr_ovf` in a cycle sets register bit 5 at the next clock edge.
- R3: Register bit 0 is the master enable, bit 1 the external enable and bit 2 the timer enable. Bits 4 and 5 are the flags and are also loaded by a write. Bits 3, 6 and 7 read 0. Any address other than REG_ADDR reads 0, and a write to such an address changes nothing.
- R4: A source is accepted only if its flag, its own enable and the master enable are all 1 and `stack_full` is 0.
- R5: On acceptance, `irq_take` is 1 in that cycle. `irq_vector` is 0x04 for the external source and 0x08 for the timer source.
- R6: At the clock edge of an acceptance, the accepted source's flag and the master enable are cleared. The other flag keeps its value.
- R7: When both sources are eligible, the external source is accepted and the timer flag stays set.
- R8: `irq_take` is never 1 in a cycle where `t2_strobe` is 0. A request pending between strobes is taken at the next strobe.
- R9: `reti_strobe` sets the master enable. `ret_strobe` leaves it unchanged.
- R10: A flag stays set until its source is accepted or software writes a 0 to that bit.
- R11: If a hardware set and a software write of 0 hit the same flag in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| t2_strobe | input | 1 | Phase strobe; requests are evaluated in cycles where it is high |
| ext_irq_n | input | 1 | External interrupt pin, active low, asynchronous |
| tmr_ovf | input | 1 | Timer overflow pulse |
| stack_full | input | 1 | Core stack is full; blocks acceptance |
| ret_strobe | input | 1 | Plain return executed |
| reti_strobe | input | 1 | Interrupt return executed |
| reg_addr | input | ADDR_W | Data address for register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (0 when the address does not match) |
| irq_take | output | 1 | Interrupt accepted this cycle |
| irq_vector | output | VEC_W | Vector address of the accepted source |

## Verification
The bench uses the default parameters: an 8-bit address with the register at 0x0B, 8-bit vectors and a two-flop synchronizer. With these values the whole acceptance space is small. The bench sweeps all 64 combinations of the three enables, the two flags and stack-full. For each one it checks the take pulse and vector both with and without the strobe, and then checks the register state after the edge. Directed sequences then cover the edge detector's timing, return behaviour, address decoding and the set-versus-clear collision.

// File: rtl/irq_pair_ctrl.sv
module irq_pair_ctrl #(
  parameter int ADDR_W      = 8,
  parameter int REG_ADDR    = 'h0B,
  parameter int VEC_W       = 8,
  parameter int VEC_EXT     = 'h04,
  parameter int VEC_TMR     = 'h08,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              t2_strobe,
  input  logic              ext_irq_n,
  input  logic              tmr_ovf,
  input  logic              stack_full,
  input  logic              ret_strobe,
  input  logic              reti_strobe,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_take,
  output logic [VEC_W-1:0]  irq_vector
);
  localparam logic [ADDR_W-1:0] SEL     = ADDR_W'(REG_ADDR);
  localparam logic [VEC_W-1:0]  V_EXT   = VEC_W'(VEC_EXT);
  localparam logic [VEC_W-1:0]  V_TMR   = VEC_W'(VEC_TMR);

  logic [SYNC_STAGES:0] pin_q;
  logic mie, een, ten, eflag, tflag;
  logic sel, wr_hit, ext_fall;
  logic ext_ok, tmr_ok, take_ext, take_tmr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_q <= '1;
    else        pin_q <= {pin_q[SYNC_STAGES-1:0], ext_irq_n};

  assign ext_fall = pin_q[SYNC_STAGES] & ~pin_q[SYNC_STAGES-1];
  assign sel      = (reg_addr == SEL);
  assign wr_hit   = reg_wr & sel;

  assign ext_ok   = eflag & een & mie & ~stack_full;
  assign tmr_ok   = tflag & ten & mie & ~stack_full;
  assign take_ext = t2_strobe & ext_ok;
  assign take_tmr = t2_strobe & tmr_ok & ~ext_ok;
  assign irq_take   = take_ext | take_tmr;
  assign irq_vector = take_ext ? V_EXT : (take_tmr ? V_TMR : '0);

  assign reg_rdata = sel ? {2'b00, tflag, eflag, 1'b0, ten, een, mie} : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mie <= 1'b0; een <= 1'b0; ten <= 1'b0;
      eflag <= 1'b0; tflag <= 1'b0;
    end else begin
      if (wr_hit) begin
        een <= reg_wdata[1];
        ten <= reg_wdata[2];
      end
      if (irq_take)         mie <= 1'b0;
      else if (reti_strobe) mie <= 1'b1;
      else if (wr_hit)      mie <= reg_wdata[0];

      if (ext_fall)      eflag <= 1'b1;
      else if (take_ext) eflag <= 1'b0;
      else if (wr_hit)   eflag <= reg_wdata[4];

      if (tmr_ovf)       tflag <= 1'b1;
      else if (take_tmr) tflag <= 1'b0;
      else if (wr_hit)   tflag <= reg_wdata[5];
    end

  AST_TAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (mie && !stack_full)); // R4
  AST_TAKE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> t2_strobe); // R8
  AST_VECTOR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> (irq_vector == V_EXT || irq_vector == V_TMR)); // R5
  AST_EXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_take && eflag && een) |-> irq_vector == V_EXT); // R7
  AST_MASTER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> !mie); // R6
  AST_RETI_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_strobe && !irq_take) |=> mie); // R9
  AST_RET_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && !reti_strobe && !irq_take && !wr_hit) |=> $stable(mie)); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> tflag); // R11
endmodule

// File: tb/tb_irq_pair_ctrl.sv
module tb_irq_pair_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic t2_strobe = 0, ext_irq_n = 1, tmr_ovf = 0, stack_full = 0;
  logic ret_strobe = 0, reti_strobe = 0, reg_wr = 0;
  logic [7:0] reg_addr = 8'h0B, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq_take;
  logic [7:0] irq_vector;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_pair_ctrl dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0; reg_addr = 8'h0B;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(2); rst_n = 1; idle(1);
    #1 chk("R3 reset", reg_rdata, 8'h00);
    chk("R5 reset take", irq_take, 0);

    for (int k = 0; k < 64; k++) begin
      automatic logic m = k[0], ee = k[1], te = k[2], ef = k[3], tf = k[4], sf = k[5];
      automatic logic eok = ef & ee & m & ~sf;
      automatic logic tok = tf & te & m & ~sf;
      automatic logic [7:0] st = {2'b00, tf, ef, 1'b0, te, ee, m};
      wr(8'h0B, st);
      stack_full = sf;
      #1 chk("R8 no take without strobe", irq_take, 0);
      @(negedge clk);
      chk("R10 flags held", reg_rdata, st);
      t2_strobe = 1;
      #1 chk("R4 take", irq_take, eok | tok);
      if (eok | tok) chk("R5 R7 vector", irq_vector, eok ? 8'h04 : 8'h08);
      @(negedge clk); t2_strobe = 0; stack_full = 0;
      #1 chk("R6 state after", reg_rdata,
             {2'b00, tf & ~(tok & ~eok), ef & ~eok, 1'b0, te, ee, m & ~(eok | tok)});
    end

    wr(8'h0B, 8'h00);
    @(negedge clk); ext_irq_n = 0;
    idle(2); #1 chk("R1 not yet", reg_rdata[4], 0);
    idle(1); #1 chk("R1 set", reg_rdata[4], 1);
    wr(8'h0B, 8'h00); idle(4);
    #1 chk("R1 once", reg_rdata[4], 0);
    ext_irq_n = 1; idle(4);
    #1 chk("R1 rise ignored", reg_rdata[4], 0);

    @(negedge clk); tmr_ovf = 1;
    @(negedge clk); tmr_ovf = 0;
    #1 chk("R2 timer flag", reg_rdata[5], 1);

    @(negedge clk); reg_wr = 1; reg_wdata = 8'h00; tmr_ovf = 1;
    @(negedge clk); reg_wr = 0; tmr_ovf = 0;
    #1 chk("R11 set wins", reg_rdata[5], 1);

    wr(8'h0B, 8'h06);
    @(negedge clk); ret_strobe = 1;
    @(negedge clk); ret_strobe = 0;
    #1 chk("R9 ret keeps 0", reg_rdata[0], 0);
    @(negedge clk); reti_strobe = 1;
    @(negedge clk); reti_strobe = 0;
    #1 chk("R9 reti sets", reg_rdata[0], 1);
    @(negedge clk); ret_strobe = 1;
    @(negedge clk); ret_strobe = 0;
    #1 chk("R9 ret keeps 1", reg_rdata[0], 1);

    wr(8'h0B, 8'hFF);
    #1 chk("R3 unused bits", reg_rdata, 8'h37);
    wr(8'h0C, 8'h00);
    #1 chk("R3 other write ignored", reg_rdata, 8'h37);
    @(negedge clk); reg_addr = 8'h0C;
    #1 chk("R3 other read zero", reg_rdata, 8'h00);
    reg_addr = 8'h0B;

    wr(8'h0B, 8'h13);
    @(negedge clk); t2_strobe = 1;
    #1 chk("R8 pending taken at strobe", irq_take, 1);
    chk("R5 ext vector", irq_vector, 8'h04);
    @(negedge clk); t2_strobe = 0;
    @(negedge clk); reti_strobe = 1; wr(8'h0B, 8'h25);
    reti_strobe = 0;
    @(negedge clk); t2_strobe = 1;
    #1 chk("R5 tmr vector", irq_vector, 8'h08);
    @(negedge clk); t2_strobe = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule